// File: doc/BRIEF.md
# Transceiver Operating Mode Controller

This block turns two mode pins and a small configuration word into the set of power-enable signals for a radio transceiver. The pins are an enable pin and a receive/transmit pin. The configuration word has three parts: a 2-bit mode field, a 2-bit selector for single, MIMO master or MIMO slave operation, and a delay count for the external power amplifier. The block drives enables for the receive path, the transmit path, the PLL/VCO, the reference clock output, the LNA, the PA driver, the AM-detector calibration path, the receive loopback calibration path and the external PA.

Every output comes from a register, so each output reflects the inputs sampled at the previous rising clock edge. The PLL/VCO enable depends on the configuration. A slave unit takes its LO from outside, so its own synthesizer is never enabled. The clock-output enable depends on the two pins alone. In transmit mode the external PA enable waits a programmable number of cycles after the transmit path turns on, so the amplifier comes up only once the drive chain has settled.

Top module: `trx_mode_ctrl`

## Requirements
- R1: While rst_n is low, every output is 0. After reset, each output shows the decode of the inputs sampled at the previous rising clock edge.
- R2: With pin_en = 0 and pin_rxtx = 0 (shutdown), every output is 0 whatever the mode field and the configuration.
- R3: With pin_en = 0 and pin_rxtx = 1, mode field 01 gives standby, where only pll_en (subject to R9) and clk_out_en are on. Any other field value gives clock-out, where only clk_out_en is on.
- R4: clk_out_en equals pin_en OR pin_rxtx. It does not depend on the mode field or the configuration.
- R5: With pin_en = 1, mode field 01 and pin_rxtx = 1 (receive), rx_en, lna_en and pll_en (R9) are on, together with clk_out_en. All other outputs are off.
- R6: With pin_en = 1, mode field 01 and pin_rxtx = 0 (transmit), tx_en, pa_drv_en and pll_en (R9) are on, together with clk_out_en. pa_en follows R11.
- R7: With pin_en = 1, mode field 11 and pin_rxtx = 0 (transmit calibration), tx_en, am_det_en, pll_en (R9) and clk_out_en are on. pa_drv_en, pa_en, lna_en and rx_en are off.
- R8: With pin_en = 1, mode field 11 and pin_rxtx = 1 (receive calibration), rx_en, tx_en, loopback_en, pll_en (R9) and clk_out_en are on. lna_en, pa_drv_en and pa_en are off.
- R9: The configuration selector is encoded 00 single, 01 master, 10 slave, and 11 behaves as single. With the selector at 10, pll_en is always 0. With any other selector value, pll_en is on in standby, receive, transmit and both calibration modes.
- R10: With pin_en = 1 and mode field 00 or 10, only clk_out_en is on.
- R11: In transmit mode with pa_delay = D held constant, pa_en rises D cycles after tx_en rises. With D = 0 it rises in the same cycle as tx_en.
- R12: pa_en falls at the same edge at which the outputs leave transmit mode. On every re-entry into transmit mode the full delay runs again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_en | input | 1 | Enable mode pin |
| pin_rxtx | input | 1 | Receive/transmit mode pin |
| mode_fld | input | 2 | Mode field from the register bank |
| cfg_sel | input | 2 | 00 single, 01 master, 10 slave, 11 as single |
| pa_delay | input | DLY_W | External PA turn-on delay in cycles |
| rx_en | output | 1 | Receive path enable |
| tx_en | output | 1 | Transmit path enable |
| pll_en | output | 1 | PLL/VCO enable |
| clk_out_en | output | 1 | Reference clock output enable |
| lna_en | output | 1 | LNA enable |
| pa_drv_en | output | 1 | PA driver enable |
| am_det_en | output | 1 | AM detector to receive buffers enable |
| loopback_en | output | 1 | Transmit-to-receive loopback enable |
| pa_en | output | 1 | External PA enable |

## Verification
The bench aims at the PA timer. It tests a zero delay, the largest delay, repeated exits and re-entries, and exits from transmit into transmit calibration, which keeps tx_en high. A timer that did not restart, or that counted one cycle too many or too few, would turn the PA on early or late. The bench also sweeps every mode-field value under each pin pair and each configuration. A decoder that let the field into the shutdown or clock-output decision would switch clk_out_en wrongly. A decoder that ignored the slave selector would power a synthesizer that must stay off.

// File: rtl/trx_mode_pkg.sv
package trx_mode_pkg;

   typedef enum logic [2:0] {
      M_OFF, M_STBY, M_CLKO, M_RX, M_TX, M_TXCAL, M_RXCAL, M_IDLE
   } mode_e;

   localparam logic [1:0] CFG_SLAVE = 2'b10;
   localparam logic [1:0] FLD_RUN   = 2'b01;
   localparam logic [1:0] FLD_CAL   = 2'b11;

   typedef struct packed {
      logic rx;
      logic tx;
      logic pll;
      logic clko;
      logic lna;
      logic padrv;
      logic amdet;
      logic loopbk;
   } pwr_t;

   localparam int PWR_W = $bits(pwr_t);

endpackage

// File: rtl/trx_mode_decode.sv
module trx_mode_decode
   import trx_mode_pkg::*;
(
   input  logic       pin_en,
   input  logic       pin_rxtx,
   input  logic [1:0] mode_fld,
   input  logic [1:0] cfg_sel,
   output pwr_t       pwr,
   output logic       tx_active
);

   mode_e mode;
   logic  pll_local;

   assign pll_local = (cfg_sel != CFG_SLAVE);

   always_comb begin
      if (!pin_en) begin
         if (!pin_rxtx)                mode = M_OFF;
         else if (mode_fld == FLD_RUN) mode = M_STBY;
         else                          mode = M_CLKO;
      end else begin
         case (mode_fld)
            FLD_RUN: mode = pin_rxtx ? M_RX    : M_TX;
            FLD_CAL: mode = pin_rxtx ? M_RXCAL : M_TXCAL;
            default: mode = M_IDLE;
         endcase
      end
   end

   always_comb begin
      pwr      = '0;
      pwr.clko = pin_en | pin_rxtx;
      case (mode)
         M_STBY:  pwr.pll = pll_local;
         M_RX: begin
            pwr.rx  = 1'b1;
            pwr.lna = 1'b1;
            pwr.pll = pll_local;
         end
         M_TX: begin
            pwr.tx    = 1'b1;
            pwr.padrv = 1'b1;
            pwr.pll   = pll_local;
         end
         M_TXCAL: begin
            pwr.tx    = 1'b1;
            pwr.amdet = 1'b1;
            pwr.pll   = pll_local;
         end
         M_RXCAL: begin
            pwr.rx     = 1'b1;
            pwr.tx     = 1'b1;
            pwr.loopbk = 1'b1;
            pwr.pll    = pll_local;
         end
         default: ;
      endcase
   end

   assign tx_active = (mode == M_TX);

endmodule

// File: rtl/trx_pa_timer.sv
module trx_pa_timer #(
   parameter int DLY_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tx_active,
   input  logic [DLY_W-1:0] delay,
   output logic             pa_next
);

   logic [DLY_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (!tx_active)
         cnt <= '0;
      else if (cnt < delay)
         cnt <= cnt + 1'b1;
   end

   assign pa_next = tx_active && (cnt >= delay);

endmodule

// File: rtl/trx_en_reg.sv
module trx_en_reg #(
   parameter int W         = 9,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (ASYNC_RST) begin : g_async
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_sync
         always_ff @(posedge clk) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end
   endgenerate

endmodule

// File: rtl/trx_mode_ctrl.sv
module trx_mode_ctrl
   import trx_mode_pkg::*;
#(
   parameter int DLY_W     = 8,
   parameter bit ASYNC_RST = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_en,
   input  logic             pin_rxtx,
   input  logic [1:0]       mode_fld,
   input  logic [1:0]       cfg_sel,
   input  logic [DLY_W-1:0] pa_delay,
   output logic             rx_en,
   output logic             tx_en,
   output logic             pll_en,
   output logic             clk_out_en,
   output logic             lna_en,
   output logic             pa_drv_en,
   output logic             am_det_en,
   output logic             loopback_en,
   output logic             pa_en
);

   localparam int OUT_W = PWR_W + 1;

   generate
      if (DLY_W < 1 || DLY_W > 24) begin : g_bad_dly_w
         $error("trx_mode_ctrl: DLY_W must be 1..24");
      end
   endgenerate

   pwr_t             pwr_d;
   logic             tx_active;
   logic             pa_d;
   logic [OUT_W-1:0] out_q;
   pwr_t             pwr_q;

   trx_mode_decode u_dec (
      .pin_en    (pin_en),
      .pin_rxtx  (pin_rxtx),
      .mode_fld  (mode_fld),
      .cfg_sel   (cfg_sel),
      .pwr       (pwr_d),
      .tx_active (tx_active)
   );

   trx_pa_timer #(.DLY_W(DLY_W)) u_pa (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_active (tx_active),
      .delay     (pa_delay),
      .pa_next   (pa_d)
   );

   trx_en_reg #(.W(OUT_W), .ASYNC_RST(ASYNC_RST)) u_reg (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({pwr_d, pa_d}),
      .q     (out_q)
   );

   assign pwr_q       = pwr_t'(out_q[OUT_W-1:1]);
   assign pa_en       = out_q[0];
   assign rx_en       = pwr_q.rx;
   assign tx_en       = pwr_q.tx;
   assign pll_en      = pwr_q.pll;
   assign clk_out_en  = pwr_q.clko;
   assign lna_en      = pwr_q.lna;
   assign pa_drv_en   = pwr_q.padrv;
   assign am_det_en   = pwr_q.amdet;
   assign loopback_en = pwr_q.loopbk;

endmodule

// File: rtl/trx_mode_ctrl_chk.sv
module trx_mode_ctrl_chk #(
   parameter int DLY_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pin_en,
   input logic             pin_rxtx,
   input logic [1:0]       mode_fld,
   input logic [1:0]       cfg_sel,
   input logic [DLY_W-1:0] pa_delay,
   input logic             rx_en,
   input logic             tx_en,
   input logic             pll_en,
   input logic             clk_out_en,
   input logic             lna_en,
   input logic             pa_drv_en,
   input logic             am_det_en,
   input logic             loopback_en,
   input logic             pa_en
);

   // R2
   shutdown_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!pin_en && !pin_rxtx) |=> !(rx_en || tx_en || pll_en || clk_out_en ||
                                   lna_en || pa_drv_en || am_det_en || loopback_en || pa_en));

   // R4
   clkout_from_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pin_en || pin_rxtx) |=> clk_out_en);

   // R9
   slave_pll_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_sel == 2'b10) |=> !pll_en);

   // R7 R8 (one front-end or calibration path at a time)
   path_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({lna_en, pa_drv_en, am_det_en, loopback_en}));

   // R6
   pa_needs_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pa_en |-> (tx_en && pa_drv_en));

   // R12
   pa_drop_on_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(pin_en && !pin_rxtx && mode_fld == 2'b01) |=> !pa_en);

   // R11
   pa_waits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(pa_en) && $past(pa_delay) != '0) |-> $past(tx_en));

endmodule

bind trx_mode_ctrl trx_mode_ctrl_chk #(.DLY_W(DLY_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .pin_en      (pin_en),
   .pin_rxtx    (pin_rxtx),
   .mode_fld    (mode_fld),
   .cfg_sel     (cfg_sel),
   .pa_delay    (pa_delay),
   .rx_en       (rx_en),
   .tx_en       (tx_en),
   .pll_en      (pll_en),
   .clk_out_en  (clk_out_en),
   .lna_en      (lna_en),
   .pa_drv_en   (pa_drv_en),
   .am_det_en   (am_det_en),
   .loopback_en (loopback_en),
   .pa_en       (pa_en)
);

// File: tb/trx_mode_ctrl_test.sv
module trx_mode_ctrl_test;

   localparam int DLY_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             pin_en = 1'b0, pin_rxtx = 1'b0;
   logic [1:0]       mode_fld = 2'b00, cfg_sel = 2'b00;
   logic [DLY_W-1:0] pa_delay = '0;
   logic rx_en, tx_en, pll_en, clk_out_en, lna_en, pa_drv_en, am_det_en, loopback_en, pa_en;

   int checks = 0, failures = 0;
   int run_len = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   trx_mode_ctrl #(.DLY_W(DLY_W)) uut (
      .clk(clk), .rst_n(rst_n), .pin_en(pin_en), .pin_rxtx(pin_rxtx),
      .mode_fld(mode_fld), .cfg_sel(cfg_sel), .pa_delay(pa_delay),
      .rx_en(rx_en), .tx_en(tx_en), .pll_en(pll_en), .clk_out_en(clk_out_en),
      .lna_en(lna_en), .pa_drv_en(pa_drv_en), .am_det_en(am_det_en),
      .loopback_en(loopback_en), .pa_en(pa_en)
   );

   // expected {rx,tx,pll,clko,lna,padrv,amdet,loopbk}
   function automatic logic [7:0] exp_vec(logic e, logic r, logic [1:0] f, logic [1:0] c);
      logic p;
      logic k;
      p = (c != 2'b10);
      k = e | r;
      if (!e && !r)      return 8'b0;                          // R2
      if (!e)            return {2'b00, p && f == 2'b01, k, 4'b0}; // R3
      if (f == 2'b01 && r)  return {1'b1, 1'b0, p, k, 1'b1, 3'b0};  // R5
      if (f == 2'b01 && !r) return {1'b0, 1'b1, p, k, 1'b0, 1'b1, 2'b0}; // R6
      if (f == 2'b11 && !r) return {1'b0, 1'b1, p, k, 2'b00, 1'b1, 1'b0}; // R7
      if (f == 2'b11 && r)  return {1'b1, 1'b1, p, k, 3'b000, 1'b1};  // R8
      return {3'b000, k, 4'b0};                                 // R10
   endfunction

   function automatic string tag_of(logic e, logic r, logic [1:0] f, logic [1:0] c);
      if (c == 2'b10 && (e || r)) return "R9";
      if (!e && !r)  return "R2";
      if (!e)        return "R3";
      if (f == 2'b01) return r ? "R5" : "R6";
      if (f == 2'b11) return r ? "R8" : "R7";
      return "R10";
   endfunction

   function automatic logic [7:0] act_vec();
      return {rx_en, tx_en, pll_en, clk_out_en, lna_en, pa_drv_en, am_det_en, loopback_en};
   endfunction

   // one cycle: drive at negedge, compare at following negedge
   task automatic cyc(logic e, logic r, logic [1:0] f, logic [1:0] c);
      logic [7:0] ev;
      logic       ep;
      bit         txm;
      pin_en = e; pin_rxtx = r; mode_fld = f; cfg_sel = c;
      @(posedge clk);
      txm = e && !r && f == 2'b01;
      run_len = txm ? run_len + 1 : 0;
      @(negedge clk);
      ev = exp_vec(e, r, f, c);
      ep = txm && (run_len > int'(pa_delay));
      checks++;
      if (act_vec() !== ev) begin
         failures++;
         $display("FAIL %s (R4 clk_out) outputs act=%b exp=%b in e=%b r=%b f=%b c=%b",
                  tag_of(e, r, f, c), act_vec(), ev, e, r, f, c);
      end
      checks++;
      if (pa_en !== ep) begin
         failures++;
         $display("FAIL %s pa_en act=%b exp=%b run=%0d dly=%0d",
                  (run_len == 0) ? "R12" : "R11", pa_en, ep, run_len, pa_delay);
      end
   endtask

   task automatic set_delay(int d);
      cyc(1'b0, 1'b0, 2'b01, cfg_sel);
      pa_delay = DLY_W'(d);
   endtask

   task automatic hold_tx(int n, logic [1:0] c);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'b01, c);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240607));
      pin_en = 1'b1; pin_rxtx = 1'b0; mode_fld = 2'b01;
      repeat (3) @(negedge clk);
      // R1 reset state with transmit inputs applied
      checks++;
      if ({act_vec(), pa_en} !== 9'b0) begin
         failures++;
         $display("FAIL R1 reset act=%b exp=%b", {act_vec(), pa_en}, 9'b0);
      end
      rst_n = 1'b1;
      pin_en = 1'b0; pin_rxtx = 1'b0;
      @(negedge clk);

      // R2 R3 R4 R9 R10: full sweep of pins, field and config
      for (int c = 0; c < 4; c++)
         for (int f = 0; f < 4; f++)
            for (int p = 0; p < 4; p++)
               cyc(p[1], p[0], 2'(f), 2'(c));

      // R11 zero delay
      set_delay(0);
      hold_tx(3, 2'b00);
      // R11 R12 delay 5, exit and re-entry
      set_delay(5);
      hold_tx(8, 2'b01);
      cyc(1'b1, 1'b0, 2'b11, 2'b01);          // R12 into Tx calibration
      hold_tx(7, 2'b01);                       // R12 full restart
      cyc(1'b1, 1'b1, 2'b01, 2'b01);
      hold_tx(3, 2'b10);
      // R11 largest delay
      set_delay((1 << DLY_W) - 1);
      hold_tx((1 << DLY_W) + 3, 2'b00);
      set_delay(1);
      hold_tx(4, 2'b11);

      // random segments
      for (int s = 0; s < 60; s++) begin
         set_delay($urandom % 10);
         for (int k = 0; k < 12; k++) begin
            logic [3:0] pick;
            int n;
            pick = 4'($urandom);
            n = 1 + ($urandom % 12);
            for (int j = 0; j < n; j++)
               if (pick[3]) cyc(1'b1, 1'b0, 2'b01, pick[1:0]);
               else cyc(pick[2], pick[1], 2'($urandom), 2'($urandom));
         end
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule